// File: doc/BRIEF.md
# One-Hot Instruction Step Sequencer

This block supplies the timing for a small processor. One fast base tick drives it. A free-running tick counter divides that tick into clock periods of four ticks each. From the counter position the block derives a level clock that follows 0, 1, 1, 0 across the four ticks. It also derives a capture strobe that is high for a single tick in the middle of each period.

A ring of seven one-hot step wires moves forward by one position on every capture strobe. After the seventh step it returns to the first. Three phase flags decode the ring into groups. Steps 1 to 3 form the fetch phase, which is the same for every instruction. Steps 4 to 6 form the execute phase, which depends on the instruction. Step 7 forms the retire phase, which closes the lap. Control gating elsewhere in the chip watches the individual step wires. No encoded step number is given out.

Top module: `instr_step_seq`

## Requirements
- R1: The tick index counts 0,1,2,3 and then wraps to 0. `cpu_clk_o` is low at index 0, high at indices 1 and 2, and low at index 3. A period is therefore four base ticks long.
- R2: `capture_o` is high only at tick index 2, which is the second high tick of `cpu_clk_o`. It is high for exactly one tick per period.
- R3: `step_o` has seven bits, with bit i standing for step i+1. Exactly one bit is high on every tick after reset.
- R4: The active step moves from bit i to bit i+1 in the tick after a tick where `capture_o` is high. In every other tick `step_o` holds its value.
- R5: The step after bit 6 (step 7) is bit 0 (step 1). One full lap lasts seven periods, which is 28 base ticks, and then the sequence repeats exactly.
- R6: `fetch_o` is high exactly when bit 0, 1 or 2 is set. `exec_o` is high exactly when bit 3, 4 or 5 is set. `retire_o` is high exactly when bit 6 is set. Exactly one of the three flags is high at any time.
- R7: The synchronous reset `rst_i` acts at a clock edge. It sets the tick index to 0 and `step_o` to 7'b0000001, which drives `cpu_clk_o` and `capture_o` low. The state stays there for as long as `rst_i` is held. After release, the sequence restarts from index 0 with step 1, including when reset is applied in the middle of a lap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base tick |
| rst_i | input | 1 | Synchronous reset, active high |
| cpu_clk_o | output | 1 | Derived level clock, pattern 0,1,1,0 per period |
| capture_o | output | 1 | One-tick mid-period capture strobe |
| step_o | output | 7 | One-hot step wires, bit 0 = step 1 |
| fetch_o | output | 1 | Active step is in the fetch group (steps 1-3) |
| exec_o | output | 1 | Active step is in the execute group (steps 4-6) |
| retire_o | output | 1 | Active step is the final step (step 7) |

## Verification
The bench runs several laps and compares the outputs on every tick. This catches a stepper that moves on the clock's rising edge rather than on the strobe: its step change would appear one or two ticks early. It also catches a ring that wraps from step 7 to step 2, or one that never wraps. Either would show up as a lap length other than 28 ticks. The bench holds reset for several ticks and also applies it in the middle of a lap. A design that resets only the counter or only the ring would come back out of alignment. The bench also watches the group boundaries between steps 3/4 and 6/7, where an off-by-one decode would raise two flags at once or none.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

  // Level of the derived clock at a given tick index.
  function automatic logic clock_level(input int unsigned idx,
                                       input int unsigned hi_first,
                                       input int unsigned hi_last);
    return (idx >= hi_first) && (idx <= hi_last);
  endfunction

  // Tick index following idx in a period of len ticks.
  function automatic int unsigned next_tick(input int unsigned idx,
                                            input int unsigned len);
    return (idx == len - 1) ? 0 : idx + 1;
  endfunction

  // Ring position feeding position pos when the ring moves forward.
  function automatic int unsigned ring_source(input int unsigned pos,
                                              input int unsigned len);
    return (pos == 0) ? len - 1 : pos - 1;
  endfunction

  // Phase group of a step position: 0 fetch, 1 execute, 2 retire.
  function automatic int unsigned phase_of(input int unsigned pos,
                                           input int unsigned n_fetch,
                                           input int unsigned n_exec);
    if (pos < n_fetch) return 0;
    if (pos < n_fetch + n_exec) return 1;
    return 2;
  endfunction

endpackage

// File: rtl/tick_phase_gen.sv
module tick_phase_gen
  import step_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_PERIOD = 4,
  parameter int unsigned HIGH_FIRST       = 1,
  parameter int unsigned HIGH_LAST        = 2,
  parameter int unsigned STROBE_TICK      = 2,
  localparam int unsigned CNT_W = (TICKS_PER_PERIOD > 1) ? $clog2(TICKS_PER_PERIOD) : 1
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic cpu_clk_o,
  output logic strobe_o,
  output logic period_end_o
);

  logic [CNT_W-1:0] tick_q;
  logic [CNT_W-1:0] tick_d;

  always_comb begin
    tick_d = CNT_W'(next_tick(int'(tick_q), TICKS_PER_PERIOD));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) tick_q <= '0;
    else       tick_q <= tick_d;
  end

  always_comb begin
    cpu_clk_o    = clock_level(int'(tick_q), HIGH_FIRST, HIGH_LAST);
    strobe_o     = (int'(tick_q) == STROBE_TICK);
    period_end_o = (int'(tick_q) == TICKS_PER_PERIOD - 1);
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_o |=> !strobe_o); // R2
  AST_STROBE_IN_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_o |-> cpu_clk_o); // R2
  AST_CLK_FALL_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(cpu_clk_o) |-> $past(strobe_o)); // R1
  AST_PERIOD_END_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    period_end_o |-> !cpu_clk_o); // R1

endmodule

// File: rtl/onehot_ring.sv
module onehot_ring
  import step_seq_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 advance_i,
  output logic [NUM_STEPS-1:0] ring_o,
  output logic                 lap_wrap_o
);

  logic [NUM_STEPS-1:0] ring_q;
  logic [NUM_STEPS-1:0] ring_d;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_pos
    localparam int unsigned SRC = ring_source(g, NUM_STEPS);
    always_comb begin
      ring_d[g] = advance_i ? ring_q[SRC] : ring_q[g];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) ring_q <= NUM_STEPS'(1);
    else       ring_q <= ring_d;
  end

  always_comb begin
    ring_o     = ring_q;
    lap_wrap_o = advance_i && ring_q[NUM_STEPS-1];
  end

  AST_RING_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(ring_o) == 1); // R3
  AST_RING_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !advance_i |=> $stable(ring_o)); // R4
  AST_RING_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    lap_wrap_o |=> ring_o[0]); // R5

endmodule

// File: rtl/phase_decode.sv
module phase_decode
  import step_seq_pkg::*;
#(
  parameter int unsigned NUM_STEPS   = 7,
  parameter int unsigned FETCH_STEPS = 3,
  parameter int unsigned EXEC_STEPS  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [NUM_STEPS-1:0] step_i,
  output logic                 fetch_o,
  output logic                 exec_o,
  output logic                 retire_o
);

  logic [NUM_STEPS-1:0] fetch_mask;
  logic [NUM_STEPS-1:0] exec_mask;
  logic [NUM_STEPS-1:0] retire_mask;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_mask
    localparam int unsigned GRP = phase_of(g, FETCH_STEPS, EXEC_STEPS);
    assign fetch_mask[g]  = (GRP == 0);
    assign exec_mask[g]   = (GRP == 1);
    assign retire_mask[g] = (GRP == 2);
  end

  always_comb begin
    fetch_o  = |(step_i & fetch_mask);
    exec_o   = |(step_i & exec_mask);
    retire_o = |(step_i & retire_mask);
  end

  AST_PHASE_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones({fetch_o, exec_o, retire_o}) == 1); // R6
  AST_RETIRE_LAST: assert property (@(posedge clk_i) disable iff (rst_i)
    retire_o |-> step_i[NUM_STEPS-1]); // R6

endmodule

// File: rtl/instr_step_seq.sv
module instr_step_seq
  import step_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_PERIOD = 4,
  parameter int unsigned HIGH_FIRST       = 1,
  parameter int unsigned HIGH_LAST        = 2,
  parameter int unsigned STROBE_TICK      = 2,
  parameter int unsigned NUM_STEPS        = 7,
  parameter int unsigned FETCH_STEPS      = 3,
  parameter int unsigned EXEC_STEPS       = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  output logic                 cpu_clk_o,
  output logic                 capture_o,
  output logic [NUM_STEPS-1:0] step_o,
  output logic                 fetch_o,
  output logic                 exec_o,
  output logic                 retire_o
);

  localparam logic [NUM_STEPS-1:0] FIRST_STEP = NUM_STEPS'(1);

  logic capture_w;
  logic period_end_w;
  logic lap_wrap_w;
  logic [NUM_STEPS-1:0] ring_w;

  tick_phase_gen #(
    .TICKS_PER_PERIOD(TICKS_PER_PERIOD),
    .HIGH_FIRST      (HIGH_FIRST),
    .HIGH_LAST       (HIGH_LAST),
    .STROBE_TICK     (STROBE_TICK)
  ) u_tick (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cpu_clk_o   (cpu_clk_o),
    .strobe_o    (capture_w),
    .period_end_o(period_end_w)
  );

  onehot_ring #(
    .NUM_STEPS(NUM_STEPS)
  ) u_ring (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .advance_i (capture_w),
    .ring_o    (ring_w),
    .lap_wrap_o(lap_wrap_w)
  );

  phase_decode #(
    .NUM_STEPS  (NUM_STEPS),
    .FETCH_STEPS(FETCH_STEPS),
    .EXEC_STEPS (EXEC_STEPS)
  ) u_phase (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .step_i  (ring_w),
    .fetch_o (fetch_o),
    .exec_o  (exec_o),
    .retire_o(retire_o)
  );

  assign capture_o = capture_w;
  assign step_o    = ring_w;

  AST_RESET_STATE: assert property (@(posedge clk_i)
    rst_i |=> (step_o == FIRST_STEP) && !cpu_clk_o && !capture_o); // R7
  AST_STEP_MOVES_AFTER_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
    capture_o |=> (step_o != $past(step_o))); // R4
  AST_NO_CAPTURE_AT_END: assert property (@(posedge clk_i) disable iff (rst_i)
    period_end_w |-> !capture_o); // R2
  AST_WRAP_IN_RETIRE: assert property (@(posedge clk_i) disable iff (rst_i)
    lap_wrap_w |-> retire_o); // R5

endmodule

// File: tb/instr_step_seq_tb_top.sv
module instr_step_seq_tb_top;

  typedef struct {
    logic       clk_l;
    logic       strobe;
    logic [6:0] step;
    logic       fetch;
    logic       exec;
    logic       retire;
    bit         in_reset;
    bit         wrap_tick;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_i = 1'b1;
  logic cpu_clk_o, capture_o, fetch_o, exec_o, retire_o;
  logic [6:0] step_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  instr_step_seq dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .cpu_clk_o(cpu_clk_o), .capture_o(capture_o),
    .step_o(step_o), .fetch_o(fetch_o), .exec_o(exec_o), .retire_o(retire_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Expected outputs k ticks after the last reset edge.
  task automatic push_expect(input int k, input bit rst_item);
    exp_t e;
    int idx, pos;
    idx = k % 4;
    pos = ((k + 1) / 4) % 7;
    e.clk_l     = (idx == 1) || (idx == 2);
    e.strobe    = (idx == 2);
    e.step      = 7'(1 << pos);
    e.fetch     = (pos <= 2);
    e.exec      = (pos >= 3) && (pos <= 5);
    e.retire    = (pos == 6);
    e.in_reset  = rst_item;
    e.wrap_tick = (pos == 0) && (k >= 3) && (idx == 3);
    exp_q.push_back(e);
  endtask

  // Monitor: compares each sampled tick against the scoreboard.
  logic [6:0] prev_step;
  logic       prev_strobe;
  bit         have_prev = 1'b0;
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (e.in_reset) begin
        check(step_o == 7'b0000001, "R7", "reset step", step_o, 7'b0000001);
        check(!cpu_clk_o && !capture_o, "R7", "reset clk/strobe",
              {5'b0, cpu_clk_o, capture_o}, 7'b0);
        have_prev = 1'b0;
      end else begin
        check(cpu_clk_o == e.clk_l, "R1", "clock level", {6'b0, cpu_clk_o}, {6'b0, e.clk_l});
        check(capture_o == e.strobe, "R2", "capture strobe", {6'b0, capture_o}, {6'b0, e.strobe});
        check($countones(step_o) == 1, "R3", "one-hot steps", step_o, e.step);
        if (e.wrap_tick)
          check(step_o == e.step, "R5", "lap wrap to step 1", step_o, e.step);
        else
          check(step_o == e.step, "R4", "active step", step_o, e.step);
        check({fetch_o, exec_o, retire_o} == {e.fetch, e.exec, e.retire}, "R6", "phase flags",
              {4'b0, fetch_o, exec_o, retire_o}, {4'b0, e.fetch, e.exec, e.retire});
        if (have_prev && !prev_strobe)
          check(step_o == prev_step, "R4", "step held without strobe", step_o, prev_step);
      end
      prev_step   = step_o;
      prev_strobe = capture_o;
      have_prev   = 1'b1;
    end
  end

  // Driver
  initial begin
    repeat (3) @(posedge clk_i);
    #1 push_expect(0, 1'b1);      // R7 reset state
    rst_i = 1'b0;
    for (int k = 1; k < 28 * 4 + 9; k++) begin
      @(posedge clk_i);
      #1 push_expect(k, 1'b0);     // R1..R6 across four laps
    end
    rst_i = 1'b1;                  // mid-lap reset, held three ticks (R7)
    for (int h = 0; h < 3; h++) begin
      @(posedge clk_i);
      #1 push_expect(0, 1'b1);
    end
    rst_i = 1'b0;
    for (int k = 1; k < 28 * 2 + 1; k++) begin
      @(posedge clk_i);
      #1 push_expect(k, 1'b0);     // R5 laps repeat after reset
    end
    @(posedge clk_i);
    @(posedge clk_i);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule